// File: doc/BRIEF.md
# Dual-Port Interleaving Converter Input Multiplexer

This block takes words from two parallel input ports and merges them into a single output register that drives a converter core. It runs entirely on a fast update clock at twice the input word rate. A one-cycle marker input shows which fast-clock edge lines up with the rising edge of the input-rate clock.

A two-bit mode code picks one of three behaviours. In interleaved mode both ports are captured once per input period. The earlier second-port word is sent out at the period's start, and the first-port word follows half a period later. In either single-port mode, the chosen port is captured and forwarded on every fast-clock cycle, and the other port is ignored. The fourth code is reserved. It freezes the output and raises an error flag.

The mid-period update is taken from the fast clock's phase, not from a falling edge. Because of this it does not depend on the input clock's duty cycle.

Top module: `dual_port_dac_mux`

## Requirements
- R1: While `rst_n` is low at a rising `clk_fast` edge, the output word, both port registers and `mode_err` clear to zero, and `upd_stb` is low after that edge.
- R2: The first edge after reset is treated as a port-2 slot: in mode 00 the output takes the zeroed port-2 register on that edge and the freshly captured port-1 word on the edge after.
- R3: Mode 00 (`mode_sel` = 2'b00), port-2 slot edge: both ports are captured and the output takes the port-2 register value held before that edge.
- R4: Mode 00, port-1 slot edge: the output takes the port-1 register, and neither port register changes.
- R5: Slots alternate port-2, port-1 on successive edges; `half_mark` high at an edge forces that edge to be a port-2 slot and restarts the alternation from it.
- R6: Mode 01: on every edge port 1 is captured and the output takes the previous port-1 register value (a two-edge latency from pin to output); `port2_d` is ignored and the port-2 register holds.
- R7: Mode 10: on every edge port 2 is captured and the output takes the previous port-2 register value; `port1_d` is ignored and the port-1 register holds.
- R8: Mode 11 is reserved: after such an edge `mode_err` is high, the output word and both port registers keep their values, and `upd_stb` is low.
- R9: `upd_stb` is high for the one fast cycle after each edge on which the output register was written (every edge in modes 00, 01, 10 out of reset).
- R10: The word width is the parameter `DATA_W`, default 14.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_fast | input | 1 | Update clock at twice the input word rate |
| rst_n | input | 1 | Synchronous active-low reset |
| half_mark | input | 1 | High in the fast cycle whose edge is the input-clock rising edge |
| mode_sel | input | 2 | 00 interleave, 01 port 1 only, 10 port 2 only, 11 reserved |
| port1_d | input | DATA_W | First input port word |
| port2_d | input | DATA_W | Second input port word |
| dac_q | output | DATA_W | Output register feeding the converter |
| upd_stb | output | 1 | Pulses after each output register write |
| mode_err | output | 1 | Reserved mode code seen on the previous edge |

## Verification
On every cycle, the embedded properties check the following:
- the slot alternation and the reset restart of the phase;
- that the output takes the older port-2 word on a port-2 slot and the port-1 register on a port-1 slot;
- that an unselected port register holds;
- that the reserved code freezes the output, drops the strobe and raises the error.

Some behaviours only the bench's scenarios can show:
- the full output ordering of data words against the pins;
- realignment when the marker arrives off-phase;
- mode switches in the middle of an input period;
- a reset in mid-stream.

These are compared against a behavioural model on every clock.

// File: rtl/ilv_pkg.sv
// Shared types for the dual-port interleaving multiplexer.
// Assumes the mode code is presented as {high bit, low bit} on a 2-bit bus.
package ilv_pkg;
    typedef enum logic [1:0] {
        MODE_ALT   = 2'b00,
        MODE_ONLY1 = 2'b01,
        MODE_ONLY2 = 2'b10,
        MODE_RSVD  = 2'b11
    } mode_e;

    typedef enum logic {
        SLOT_P2 = 1'b0,
        SLOT_P1 = 1'b1
    } slot_e;
endpackage

// File: rtl/ilv_phase_track.sv
// Tracks which half of the input-clock period the current fast edge belongs to.
// Assumes half_mark, when high, identifies an input-clock rising edge; without it
// the slot simply alternates. Reset restarts at the port-2 slot.
module ilv_phase_track
    import ilv_pkg::*;
(
    input  logic  clk_fast,
    input  logic  rst_n,
    input  logic  half_mark,
    output slot_e slot_now
);
    slot_e next_q;

    assign slot_now = half_mark ? SLOT_P2 : next_q;

    // Remember the slot the following edge will take.
    always_ff @(posedge clk_fast) begin
        if (!rst_n) next_q <= SLOT_P2;
        else        next_q <= (slot_now == SLOT_P2) ? SLOT_P1 : SLOT_P2;
    end

    assert_slot_alternate_R5: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (slot_now == SLOT_P1) |=> (slot_now == SLOT_P2));

    assert_restart_p2_R2: assert property (@(posedge clk_fast) disable iff (!rst_n)
        !$past(rst_n) |-> (slot_now == SLOT_P2));
endmodule

// File: rtl/ilv_port_latch.sv
// One input-port holding register with a capture enable.
// Assumes enable is decided by the caller from mode and slot.
module ilv_port_latch #(
    parameter int DATA_W = 14
) (
    input  logic              clk_fast,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] q
);
    // Capture the port word when enabled, else hold.
    always_ff @(posedge clk_fast) begin
        if (!rst_n)      q <= '0;
        else if (cap_en) q <= din;
    end

    // Covers R6 and R7: an unselected port register keeps its value.
    assert_idle_port_holds_R6: assert property (@(posedge clk_fast) disable iff (!rst_n)
        !cap_en |=> $stable(q));
endmodule

// File: rtl/ilv_out_sel.sv
// Output register, update strobe and reserved-mode flag.
// Assumes the port registers are updated on the same edge as this register,
// so it reads their pre-edge contents.
module ilv_out_sel
    import ilv_pkg::*;
#(
    parameter int DATA_W = 14
) (
    input  logic              clk_fast,
    input  logic              rst_n,
    input  mode_e             mode,
    input  slot_e             slot_now,
    input  logic [DATA_W-1:0] lat1,
    input  logic [DATA_W-1:0] lat2,
    output logic [DATA_W-1:0] dac_q,
    output logic              upd_stb,
    output logic              mode_err
);
    logic              wr_en;
    logic [DATA_W-1:0] pick;

    // Choose the register that feeds the output on this edge.
    always_comb begin
        wr_en = 1'b1;
        pick  = dac_q;
        unique case (mode)
            MODE_ALT:   pick = (slot_now == SLOT_P2) ? lat2 : lat1;
            MODE_ONLY1: pick = lat1;
            MODE_ONLY2: pick = lat2;
            default:    wr_en = 1'b0;
        endcase
    end

    // Output register with strobe and error flag.
    always_ff @(posedge clk_fast) begin
        if (!rst_n) begin
            dac_q    <= '0;
            upd_stb  <= 1'b0;
            mode_err <= 1'b0;
        end else begin
            if (wr_en) dac_q <= pick;
            upd_stb  <= wr_en;
            mode_err <= (mode == MODE_RSVD);
        end
    end

    assert_alt_p2_first_R3: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (mode == MODE_ALT && slot_now == SLOT_P2) |=> (dac_q == $past(lat2)));

    assert_alt_p1_mid_R4: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (mode == MODE_ALT && slot_now == SLOT_P1) |=> (dac_q == $past(lat1)));

    assert_rsvd_freeze_R8: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (mode == MODE_RSVD) |=> ($stable(dac_q) && mode_err && !upd_stb));

    assert_strobe_on_write_R9: assert property (@(posedge clk_fast) disable iff (!rst_n)
        (mode != MODE_RSVD) |=> (upd_stb && !mode_err));
endmodule

// File: rtl/dual_port_dac_mux.sv
// Top level: merges two input ports into one converter output register.
// Assumes clk_fast runs at twice the input word rate and half_mark flags the
// fast edge aligned with the input-clock rising edge. Reset is synchronous.
module dual_port_dac_mux
    import ilv_pkg::*;
#(
    parameter int DATA_W = 14
) (
    input  logic              clk_fast,
    input  logic              rst_n,
    input  logic              half_mark,
    input  logic [1:0]        mode_sel,
    input  logic [DATA_W-1:0] port1_d,
    input  logic [DATA_W-1:0] port2_d,
    output logic [DATA_W-1:0] dac_q,
    output logic              upd_stb,
    output logic              mode_err
);
    localparam int NPORT = 2;

    mode_e                        mode;
    slot_e                        slot_now;
    logic [NPORT-1:0][DATA_W-1:0] pin_w;
    logic [NPORT-1:0][DATA_W-1:0] lat_w;
    logic [NPORT-1:0]             cap_en;

    assign mode     = mode_e'(mode_sel);
    assign pin_w[0] = port1_d;
    assign pin_w[1] = port2_d;

    ilv_phase_track u_phase (
        .clk_fast (clk_fast),
        .rst_n    (rst_n),
        .half_mark(half_mark),
        .slot_now (slot_now)
    );

    for (genvar gi = 0; gi < NPORT; gi++) begin : g_port
        localparam mode_e SOLO = (gi == 0) ? MODE_ONLY1 : MODE_ONLY2;

        // Capture on a port-2 slot when interleaving, or always when this port is chosen alone.
        assign cap_en[gi] = (mode == MODE_ALT && slot_now == SLOT_P2) || (mode == SOLO);

        ilv_port_latch #(.DATA_W(DATA_W)) u_lat (
            .clk_fast(clk_fast),
            .rst_n   (rst_n),
            .cap_en  (cap_en[gi]),
            .din     (pin_w[gi]),
            .q       (lat_w[gi])
        );
    end

    ilv_out_sel #(.DATA_W(DATA_W)) u_out (
        .clk_fast(clk_fast),
        .rst_n   (rst_n),
        .mode    (mode),
        .slot_now(slot_now),
        .lat1    (lat_w[0]),
        .lat2    (lat_w[1]),
        .dac_q   (dac_q),
        .upd_stb (upd_stb),
        .mode_err(mode_err)
    );
endmodule

// File: tb/tb_dual_port_dac_mux.sv
// Bench: behavioural reference model compared with the design on every clock.
module tb_dual_port_dac_mux;
    localparam int  W      = 14;
    localparam time CLK_PS = 10;

    logic         clk_fast = 1'b0;
    logic         rst_n    = 1'b0;
    logic         half_mark = 1'b0;
    logic [1:0]   mode_sel = 2'b00;
    logic [W-1:0] port1_d  = '0;
    logic [W-1:0] port2_d  = '0;
    logic [W-1:0] dac_q;
    logic         upd_stb;
    logic         mode_err;

    int vectors = 0;
    int miscompares = 0;
    bit done = 1'b0;

    // model state: ph = 0 means the next edge is a port-2 slot
    logic [W-1:0] m_l1 = '0, m_l2 = '0, m_out = '0;
    logic         m_stb = 1'b0, m_err = 1'b0;
    int           m_ph = 0;

    always #(CLK_PS / 2) clk_fast = ~clk_fast;

    dual_port_dac_mux #(.DATA_W(W)) dut (
        .clk_fast (clk_fast),
        .rst_n    (rst_n),
        .half_mark(half_mark),
        .mode_sel (mode_sel),
        .port1_d  (port1_d),
        .port2_d  (port2_d),
        .dac_q    (dac_q),
        .upd_stb  (upd_stb),
        .mode_err (mode_err)
    );

    task automatic model_edge();
        int slot;
        logic [W-1:0] o1, o2;
        if (!rst_n) begin
            m_l1 = '0; m_l2 = '0; m_out = '0; m_stb = 0; m_err = 0; m_ph = 0;
            return;
        end
        slot = half_mark ? 0 : m_ph;
        m_ph = (slot == 0) ? 1 : 0;
        o1 = m_l1; o2 = m_l2;
        m_err = (mode_sel == 2'b11);
        m_stb = (mode_sel != 2'b11);
        case (mode_sel)
            2'b00: begin
                if (slot == 0) begin m_out = o2; m_l1 = port1_d; m_l2 = port2_d; end
                else m_out = o1;
            end
            2'b01: begin m_out = o1; m_l1 = port1_d; end
            2'b10: begin m_out = o2; m_l2 = port2_d; end
            default: ;
        endcase
    endtask

    task automatic compare(string tag);
        vectors++;
        if (dac_q !== m_out) begin
            miscompares++;
            $display("FAIL %s dac_q actual=%h expected=%h", tag, dac_q, m_out);
        end
        if (upd_stb !== m_stb) begin
            miscompares++;
            $display("FAIL %s upd_stb actual=%b expected=%b", tag, upd_stb, m_stb);
        end
        if (mode_err !== m_err) begin
            miscompares++;
            $display("FAIL %s mode_err actual=%b expected=%b", tag, mode_err, m_err);
        end
    endtask

    task automatic step(bit rst, bit mk, logic [1:0] md, logic [W-1:0] a, logic [W-1:0] b, string tag);
        rst_n = rst; half_mark = mk; mode_sel = md; port1_d = a; port2_d = b;
        model_edge();
        @(posedge clk_fast);
        @(negedge clk_fast);
        compare(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    initial begin
        @(negedge clk_fast);
        // R1: reset state
        step(0, 0, 2'b00, 14'h1111, 14'h2222, "R1");
        step(0, 0, 2'b01, 14'h1111, 14'h2222, "R1");

        // R2: first edges after reset, fixed words
        step(1, 0, 2'b00, 14'h0123, 14'h0456, "R2");
        step(1, 0, 2'b00, 14'h3fff, 14'h3ffe, "R2");
        step(1, 0, 2'b00, 14'h0abc, 14'h0def, "R2");
        step(1, 0, 2'b00, 14'h0000, 14'h0000, "R2");
        if (dac_q !== 14'h0abc) begin
            miscompares++;
            $display("FAIL R2 direct actual=%h expected=%h", dac_q, 14'h0abc);
        end
        vectors++;

        // R3 R4: interleaving with aligned markers
        for (int i = 0; i < 40; i++)
            step(1, (i % 2) == 0, 2'b00, W'($urandom), W'($urandom), "R3");
        // R4: free-running interleave without markers
        for (int i = 0; i < 40; i++)
            step(1, 0, 2'b00, W'($urandom), W'($urandom), "R4");
        // R5: off-phase markers realign the slot
        for (int i = 0; i < 30; i++)
            step(1, (i % 5) == 0, 2'b00, W'($urandom), W'($urandom), "R5");

        // R6: port 1 only, port 2 toggling and ignored
        for (int i = 0; i < 30; i++)
            step(1, (i % 2) == 0, 2'b01, W'($urandom), W'($urandom), "R6");
        // R7: port 2 only
        for (int i = 0; i < 30; i++)
            step(1, (i % 2) == 1, 2'b10, W'($urandom), W'($urandom), "R7");
        // R6 R7: back to interleave exposes held registers
        for (int i = 0; i < 6; i++)
            step(1, (i % 2) == 0, 2'b00, W'($urandom), W'($urandom), "R6");

        // R8: reserved code mid-stream, then recover
        for (int i = 0; i < 8; i++)
            step(1, (i % 2) == 0, 2'b11, W'($urandom), W'($urandom), "R8");
        for (int i = 0; i < 6; i++)
            step(1, (i % 2) == 0, 2'b00, W'($urandom), W'($urandom), "R8");

        // R9: random modes, strobe follows every write
        for (int i = 0; i < 200; i++)
            step(1, ($urandom % 3) == 0, 2'($urandom), W'($urandom), W'($urandom), "R9");

        // R1 R10: mid-stream reset then full-width words
        step(0, 0, 2'b10, 14'h3fff, 14'h3fff, "R1");
        for (int i = 0; i < 8; i++)
            step(1, 0, 2'b00, 14'h3fff - W'(i), 14'h2000 + W'(i), "R10");

        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk_fast);
        miscompares++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end
endmodule